// File: doc/BRIEF.md
# Interrupt Controller Mode Register

This block keeps the operating mode of a local interrupt controller. Two stored bits, an enable bit and an extended-mode bit, decide whether the controller is switched off, runs in its legacy memory-mapped mode, or runs in its extended register-access mode. Software changes the mode through a one-cycle write strobe that carries both bits at once.

Every write is checked before it is stored. A request for the forbidden combination (enable clear with extended set) is refused. The stored bits keep their old values, and a general-protection fault pulse is raised instead.

The same port also returns a read-only version word. That word is built at elaboration time from a version number, the highest local-vector-table entry index, and a directed end-of-interrupt capability flag.

Top module: `intc_mode_reg`

## Requirements
- R1: After reset the stored bits are enable=1 and extended=0, `mode_o` reads legacy (2'd1), and `fault_o` is 0.
- R2: `mode_o` encodes the stored bits as 2'd0 = disabled (enable 0, extended 0), 2'd1 = legacy (enable 1, extended 0), 2'd2 = extended (enable 1, extended 1). The value 2'd3 never appears.
- R3: A write with `wr_vld_i`=1 whose data is not the forbidden pair is stored at that clock edge: `wr_data_i[0]` becomes the enable bit and `wr_data_i[1]` becomes the extended bit.
- R4: A write whose data has `wr_data_i[0]`=0 and `wr_data_i[1]`=1 is refused. Both stored bits keep their previous values, so the forbidden pair is never held.
- R5: `fault_o` is 1 during exactly the one cycle that follows each refused write. In every other cycle it is 0.
- R6: With `rd_sel_i`=0, `rd_data_o` shows the mode register: bit 0 is the enable bit, bit 1 is the extended bit, and bits 31:2 are zero. The read is combinational.
- R7: With `rd_sel_i`=1, `rd_data_o` shows the version word: bits 7:0 are VERSION_ID, bits 23:16 are MAX_LVT_IDX, and bit 24 is HAS_DIRECTED_EOI. Bits 15:8 and 31:25 are zero.
- R8: No write, legal or refused, changes the version word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_vld_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | 2 | Write data: bit 0 is enable, bit 1 is extended |
| rd_sel_i | input | 1 | Read select: 0 selects the mode register, 1 selects the version word |
| mode_o | output | 2 | Current mode: 0 disabled, 1 legacy, 2 extended |
| fault_o | output | 1 | One-cycle fault pulse after a refused write |
| rd_data_o | output | 32 | Read data |

## Verification
A write is applied at one rising edge. The new stored bits, `mode_o`, the mode read and `fault_o` are all due one cycle later. The bench drives each write on a falling edge and samples all of these on the next falling edge. It then samples `fault_o` once more, one cycle later, to confirm the pulse has dropped. The read data has no latency: the bench changes `rd_sel_i` and samples in the same low phase of the clock. The checker relates each write to the state and the fault one edge later.

// File: rtl/intc_mode_pkg.sv
package intc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_EXT    = 2'd2,
    MODE_BAD    = 2'd3
  } mode_e;

  localparam int unsigned WORD_W = 32;

  // A request is illegal when it asks for the extended bit without the enable bit.
  function automatic logic f_illegal(input logic en, input logic ext);
    return (!en) && ext;
  endfunction

  function automatic mode_e f_mode(input logic en, input logic ext);
    case ({en, ext})
      2'b00:   return MODE_OFF;
      2'b10:   return MODE_LEGACY;
      2'b11:   return MODE_EXT;
      default: return MODE_BAD;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_version_word(input logic [7:0] ver,
                                                       input logic [7:0] lvt,
                                                       input logic       deoi);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = ver;
    w[23:16] = lvt;
    w[24]    = deoi;
    return w;
  endfunction

endpackage

// File: rtl/intc_mode_state.sv
module intc_mode_state (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_vld_i,
  input  logic [1:0] wr_data_i,
  output logic       en_q_o,
  output logic       ext_q_o,
  output logic       wr_illegal_o,
  output logic       fault_q_o
);
  import intc_mode_pkg::*;

  logic en_q, ext_q, fault_q;
  logic req_illegal;

  assign req_illegal = f_illegal(wr_data_i[0], wr_data_i[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      ext_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_vld_i && req_illegal;
      if (wr_vld_i && !req_illegal) begin
        en_q  <= wr_data_i[0];
        ext_q <= wr_data_i[1];
      end
    end
  end

  assign en_q_o       = en_q;
  assign ext_q_o      = ext_q;
  assign wr_illegal_o = req_illegal;
  assign fault_q_o    = fault_q;
endmodule

// File: rtl/intc_version_rom.sv
module intc_version_rom #(
  parameter logic [7:0] VERSION_ID       = 8'h14,
  parameter logic [7:0] MAX_LVT_IDX      = 8'h05,
  parameter bit         HAS_DIRECTED_EOI = 1'b1
) (
  output logic [intc_mode_pkg::WORD_W-1:0] ver_word_o
);
  import intc_mode_pkg::*;

  generate
    if (HAS_DIRECTED_EOI) begin : g_deoi
      assign ver_word_o = f_version_word(VERSION_ID, MAX_LVT_IDX, 1'b1);
    end else begin : g_no_deoi
      assign ver_word_o = f_version_word(VERSION_ID, MAX_LVT_IDX, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/intc_mode_reg.sv
module intc_mode_reg #(
  parameter logic [7:0] VERSION_ID       = 8'h14,
  parameter logic [7:0] MAX_LVT_IDX      = 8'h05,
  parameter bit         HAS_DIRECTED_EOI = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_vld_i,
  input  logic [1:0]  wr_data_i,
  input  logic        rd_sel_i,
  output logic [1:0]  mode_o,
  output logic        fault_o,
  output logic [31:0] rd_data_o
);
  import intc_mode_pkg::*;

  localparam int unsigned PAD_W = WORD_W - 2;

  logic              en_q, ext_q, wr_illegal, fault_q;
  logic [WORD_W-1:0] ver_word;
  logic [WORD_W-1:0] mode_word;
  mode_e             mode_cur;

  intc_mode_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_vld_i    (wr_vld_i),
    .wr_data_i   (wr_data_i),
    .en_q_o      (en_q),
    .ext_q_o     (ext_q),
    .wr_illegal_o(wr_illegal),
    .fault_q_o   (fault_q)
  );

  intc_version_rom #(
    .VERSION_ID      (VERSION_ID),
    .MAX_LVT_IDX     (MAX_LVT_IDX),
    .HAS_DIRECTED_EOI(HAS_DIRECTED_EOI)
  ) u_ver (
    .ver_word_o(ver_word)
  );

  assign mode_cur  = f_mode(en_q, ext_q);
  assign mode_word = {{PAD_W{1'b0}}, ext_q, en_q};

  assign mode_o    = mode_cur;
  assign fault_o   = fault_q;
  assign rd_data_o = rd_sel_i ? ver_word : mode_word;
endmodule

// File: rtl/intc_mode_chk.sv
module intc_mode_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_vld_i,
  input logic [1:0]  wr_data_i,
  input logic        wr_illegal,
  input logic        en_q,
  input logic        ext_q,
  input logic        fault_o,
  input logic [1:0]  mode_o,
  input logic [31:0] ver_word
);
  p_never_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((!en_q) && ext_q));

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  p_store_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && !wr_illegal) |=> (en_q == $past(wr_data_i[0]) && ext_q == $past(wr_data_i[1])));

  p_refuse_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && wr_illegal) |=> ($stable(en_q) && $stable(ext_q)));

  p_fault_after_refusal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && wr_illegal) |=> fault_o);

  p_fault_has_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(wr_vld_i && wr_illegal));

  p_version_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ver_word));
endmodule

bind intc_mode_reg intc_mode_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_vld_i  (wr_vld_i),
  .wr_data_i (wr_data_i),
  .wr_illegal(wr_illegal),
  .en_q      (en_q),
  .ext_q     (ext_q),
  .fault_o   (fault_o),
  .mode_o    (mode_o),
  .ver_word  (ver_word)
);

// File: tb/test_intc_mode_reg.sv
`timescale 1ns/1ps
module test_intc_mode_reg;
  localparam logic [7:0] T_VER  = 8'h15;
  localparam logic [7:0] T_LVT  = 8'h06;
  localparam bit         T_DEOI = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_vld = 1'b0;
  logic [1:0]  wr_data = 2'b00;
  logic        rd_sel = 1'b0;
  logic [1:0]  mode;
  logic        fault;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state, kept by the bench from the requirements.
  logic m_en = 1'b1;
  logic m_ext = 1'b0;

  always #4 clk = ~clk;

  intc_mode_reg #(
    .VERSION_ID(T_VER), .MAX_LVT_IDX(T_LVT), .HAS_DIRECTED_EOI(T_DEOI)
  ) i_intc_mode_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_vld_i(wr_vld), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .mode_o(mode), .fault_o(fault), .rd_data_o(rd_data)
  );

  function automatic logic [1:0] exp_mode(input logic en, input logic ext);
    if (!en) return 2'd0;
    return ext ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [31:0] exp_ver();
    return (32'(T_DEOI) << 24) | (32'(T_LVT) << 16) | 32'(T_VER);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One write: drive on a falling edge, captured at the next rising edge,
  // results sampled at the falling edge after that.
  task automatic do_write(input logic [1:0] d);
    logic bad;
    bad = (d == 2'b10);
    @(negedge clk);
    wr_vld = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
    if (!bad) begin
      m_en = d[0];
      m_ext = d[1];
    end
    rd_sel = 1'b0;
    #1;
    check("R2 mode after write", 32'(mode), 32'(exp_mode(m_en, m_ext)));
    check("R3/R4 stored bits", rd_data, {30'b0, m_ext, m_en});
    check("R5 fault pulse", 32'(fault), 32'(bad));
    @(negedge clk);
    check("R5 fault drops", 32'(fault), 32'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset mode", 32'(mode), 32'd1);
    check("R1 reset fault", 32'(fault), 32'd0);
    check("R6 reset read", rd_data, 32'h1);
  endtask

  task automatic t_all_pairs();
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        do_write(2'(f));
        do_write(2'(t));
      end
    end
  endtask

  task automatic t_version();
    @(negedge clk);
    rd_sel = 1'b1;
    #1;
    check("R7 version word", rd_data, exp_ver());
    // Writes (legal and refused) while the version word is selected.
    wr_vld = 1'b1;
    wr_data = 2'b10;
    @(negedge clk);
    wr_data = 2'b11;
    @(negedge clk);
    wr_vld = 1'b0;
    m_en = 1'b1;
    m_ext = 1'b1;
    #1;
    check("R8 version unchanged", rd_data, exp_ver());
    rd_sel = 1'b0;
    #1;
    check("R6 mode read", rd_data, 32'h3);
    check("R5 no fault after legal", 32'(fault), 32'd0);
  endtask

  task automatic t_back_to_back_faults();
    @(negedge clk);
    wr_vld = 1'b1;
    wr_data = 2'b10;
    @(negedge clk);
    check("R5 first refused", 32'(fault), 32'd1);
    @(negedge clk);
    wr_vld = 1'b0;
    check("R5 second refused", 32'(fault), 32'd1);
    check("R4 state kept", 32'(mode), 32'(exp_mode(m_en, m_ext)));
    @(negedge clk);
    check("R5 pulse ends", 32'(fault), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_pairs();
    t_version();
    t_back_to_back_faults();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule